// File: doc/BRIEF.md
# Serial EEPROM Byte Writer with Acknowledge Polling

This block turns a single write request (a memory address plus one data byte) into the command sequence that a byte-level I2C master needs to store that byte in a serial EEPROM with two address bytes. It talks to the master through a small command channel. Each command is a start condition, one byte to send, or a stop condition. For every command the master returns one response, which carries the acknowledge bit when a byte was sent.

A fixed wait after each write would cover the EEPROM's internal programming time. This block replaces that wait with acknowledge polling. Every write opens with a start condition and the write control byte. If the device answers with a NACK, it is still busy: the block sends a stop and tries again. Once the device acknowledges, the block sends the address bytes and the data byte in the same frame and closes it with a stop. The number of poll attempts is bounded by a parameter. If the limit is reached, the request ends with a timeout flag.

A device that acknowledged its control byte is not expected to reject the following bytes. A NACK on an address or data byte is therefore only reported, and it never restarts the frame. Requests use a valid/ready handshake. Only one is in flight at a time, and each completion gives a single-cycle done pulse.

Top module: `eeprom_ackpoll_writer`

## Requirements
- R1: After reset, req_ready is 1 and cmd_valid, done, err_nack and err_timeout are 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. From the next cycle req_ready stays 0 until the cycle in which done pulses, where it is 1 again. While req_ready is 1, cmd_valid is 0.
- R3: Every accepted write begins with a poll attempt: a start command followed by a send-byte command carrying 0xA0. In that byte, bits 7:4 hold the device type 1010, bits 3:1 hold the chip select (default 000) and bit 0 is 0 for a write. Command codes on cmd_op are 0 = start, 1 = send byte, 2 = stop.
- R4: When the control byte is answered with rsp_nack = 1, the block issues a stop command and then begins a new start plus control byte attempt.
- R5: Once the control byte is acknowledged, the block sends req_addr[15:8], then req_addr[7:0], then the data byte, then a stop. After the stop's response, done pulses for exactly one cycle.
- R6: A NACK on an address or data byte never causes a retry. The frame still completes in full, and done comes with err_nack = 1 and err_timeout = 0.
- R7: If MAX_POLL control bytes in a row are NACKed, the stop after the last one ends the request: done pulses with err_timeout = 1, and no address or data byte is sent. If there are MAX_POLL-1 NACKs, the write goes ahead normally.
- R8: err_nack and err_timeout change only in the done cycle or in the cycle after an acceptance, which clears both. Between those points they hold their value.
- R9: cmd_valid, cmd_op and cmd_byte stay steady until cmd_ready accepts the command. No new command is presented while a response is outstanding.
- R10: A request held valid while the block is busy is not accepted until the previous write has finished. Its frame begins with a fresh poll after the previous stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | EEPROM memory address |
| req_data | input | 8 | Byte to store |
| done | output | 1 | One-cycle completion pulse |
| err_nack | output | 1 | An address or data byte was NACKed in the last write |
| err_timeout | output | 1 | Last write gave up after MAX_POLL poll attempts |
| cmd_valid | output | 1 | Command to the byte-level master is valid |
| cmd_ready | input | 1 | Master accepts the command |
| cmd_op | output | 2 | 0 start, 1 send byte, 2 stop |
| cmd_byte | output | 8 | Byte to send for a send-byte command |
| rsp_valid | input | 1 | Master finished the outstanding command |
| rsp_nack | input | 1 | Byte was not acknowledged (send-byte only) |

## Verification
The assertions check the behaviour that has to hold on every cycle. These are the command-channel rules: a command holds until accepted, and no command goes out while the block is idle. They also check that done lasts a single cycle, that the error flags move only at completion or acceptance, and that the poll counter never exceeds its limit. The ordering of bytes on the bus can only be shown by the bench's scenarios, which drive a model master that NACKs a chosen number of polls or a chosen body byte. Those scenarios also show the exact retry count at the timeout boundary, that a body NACK causes no retry, and that a request waiting behind a busy write is serialised.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_WRITE = 2'd1,
      OP_STOP  = 2'd2
   } eepw_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_CTRL,
      ST_PSTOP,
      ST_BODY,
      ST_ESTOP
   } eepw_state_e;
endpackage

// File: rtl/eepw_frame_src.sv
module eepw_frame_src #(
   parameter int         ADDR_W   = 16,
   parameter int         STEP_W   = 2,
   parameter logic [3:0] DEV_ID   = 4'hA,
   parameter logic [2:0] CHIP_SEL = 3'b000
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        data_i,
   input  logic [STEP_W-1:0] step_i,
   output logic [7:0]        byte_o
);
   localparam int         ADDR_BYTES = ADDR_W / 8;
   localparam logic [7:0] CTRL_WR    = {DEV_ID, CHIP_SEL, 1'b0};

   logic [7:0] addr_b [ADDR_BYTES];

   // most significant address byte goes out first
   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
      assign addr_b[g] = addr_i[ADDR_W-1-8*g -: 8];
   end

   always_comb begin
      byte_o = data_i;
      if (step_i == '0) byte_o = CTRL_WR;
      for (int k = 0; k < ADDR_BYTES; k++) begin
         if (step_i == STEP_W'(k + 1)) byte_o = addr_b[k];
      end
   end
endmodule

// File: rtl/eepw_poll_ctr.sv
module eepw_poll_ctr #(
   parameter int MAX_POLL = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);
   localparam int CNT_W = $clog2(MAX_POLL + 1);

   if (MAX_POLL < 1) begin : g_bad_limit
      $error("eepw_poll_ctr: MAX_POLL must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
   end

   if (MAX_POLL == 1) begin : g_single
      assign last_o = 1'b1;
   end else begin : g_multi
      assign last_o = (cnt_q == CNT_W'(MAX_POLL - 1));
   end

   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_POLL))
      else $error("poll counter beyond limit");
endmodule

// File: rtl/eepw_seq_fsm.sv
module eepw_seq_fsm
   import eepw_pkg::*;
#(
   parameter int STEP_W    = 2,
   parameter int LAST_STEP = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   output logic              idle_o,
   output logic              cmd_valid_o,
   input  logic              cmd_ready_i,
   output eepw_op_e          cmd_op_o,
   output logic [STEP_W-1:0] step_o,
   input  logic              rsp_valid_i,
   input  logic              rsp_nack_i,
   output logic              poll_clr_o,
   output logic              poll_inc_o,
   input  logic              poll_last_i,
   output logic              done_o,
   output logic              err_nack_o,
   output logic              err_timeout_o
);
   localparam logic [STEP_W-1:0] LAST_S = STEP_W'(LAST_STEP);

   eepw_state_e       state_q;
   logic              wait_q, to_q, nack_seen_q;
   logic              done_q, errn_q, errt_q;
   logic [STEP_W-1:0] step_q;
   logic              rsp_take;

   assign rsp_take      = wait_q && rsp_valid_i;
   assign idle_o        = (state_q == ST_IDLE);
   assign cmd_valid_o   = !idle_o && !wait_q;
   assign step_o        = (state_q == ST_BODY) ? step_q : '0;
   assign poll_clr_o    = accept_i;
   assign poll_inc_o    = rsp_take && (state_q == ST_CTRL) && rsp_nack_i;
   assign done_o        = done_q;
   assign err_nack_o    = errn_q;
   assign err_timeout_o = errt_q;

   always_comb begin
      unique case (state_q)
         ST_START:          cmd_op_o = OP_START;
         ST_PSTOP, ST_ESTOP: cmd_op_o = OP_STOP;
         default:           cmd_op_o = OP_WRITE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         wait_q      <= 1'b0;
         to_q        <= 1'b0;
         nack_seen_q <= 1'b0;
         done_q      <= 1'b0;
         errn_q      <= 1'b0;
         errt_q      <= 1'b0;
         step_q      <= '0;
      end else begin
         done_q <= 1'b0;
         if (state_q == ST_IDLE) begin
            if (accept_i) begin
               state_q     <= ST_START;
               errn_q      <= 1'b0;
               errt_q      <= 1'b0;
               nack_seen_q <= 1'b0;
               to_q        <= 1'b0;
            end
         end else if (!wait_q) begin
            if (cmd_ready_i) wait_q <= 1'b1;
         end else if (rsp_valid_i) begin
            wait_q <= 1'b0;
            unique case (state_q)
               ST_START: state_q <= ST_CTRL;
               ST_CTRL: begin
                  if (rsp_nack_i) begin
                     to_q    <= poll_last_i;
                     state_q <= ST_PSTOP;
                  end else begin
                     step_q  <= STEP_W'(1);
                     state_q <= ST_BODY;
                  end
               end
               ST_PSTOP: begin
                  if (to_q) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     errt_q  <= 1'b1;
                     errn_q  <= 1'b0;
                  end else begin
                     state_q <= ST_START;
                  end
               end
               ST_BODY: begin
                  if (rsp_nack_i) nack_seen_q <= 1'b1;
                  if (step_q == LAST_S) state_q <= ST_ESTOP;
                  else                  step_q  <= step_q + 1'b1;
               end
               ST_ESTOP: begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  errn_q  <= nack_seen_q;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q)
      else $error("done wider than one cycle");

   p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(errn_q) || !$stable(errt_q)) |-> (done_q || $past(accept_i)))
      else $error("error flags moved outside done or accept");

   p_ctrl_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_take && state_q == ST_START) |=> (cmd_op_o == OP_WRITE && step_o == '0))
      else $error("start not followed by control byte");
endmodule

// File: rtl/eeprom_ackpoll_writer.sv
module eeprom_ackpoll_writer
   import eepw_pkg::*;
#(
   parameter int         ADDR_W   = 16,
   parameter logic [3:0] DEV_ID   = 4'hA,
   parameter logic [2:0] CHIP_SEL = 3'b000,
   parameter int         MAX_POLL = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   output logic              done,
   output logic              err_nack,
   output logic              err_timeout,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [1:0]        cmd_op,
   output logic [7:0]        cmd_byte,
   input  logic              rsp_valid,
   input  logic              rsp_nack
);
   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam int LAST_STEP  = ADDR_BYTES + 1;
   localparam int STEP_W     = $clog2(LAST_STEP + 1);

   if (ADDR_W < 8 || (ADDR_W % 8) != 0) begin : g_bad_aw
      $error("eeprom_ackpoll_writer: ADDR_W must be a nonzero multiple of 8");
   end

   logic              accept, idle, poll_clr, poll_inc, poll_last;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;
   logic [STEP_W-1:0] step;
   eepw_op_e          op;

   assign req_ready = idle;
   assign accept    = req_valid && idle;
   assign cmd_op    = op;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         addr_q <= req_addr;
         data_q <= req_data;
      end
   end

   eepw_seq_fsm #(.STEP_W(STEP_W), .LAST_STEP(LAST_STEP)) u_fsm (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .idle_o(idle),
      .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(op),
      .step_o(step), .rsp_valid_i(rsp_valid), .rsp_nack_i(rsp_nack),
      .poll_clr_o(poll_clr), .poll_inc_o(poll_inc), .poll_last_i(poll_last),
      .done_o(done), .err_nack_o(err_nack), .err_timeout_o(err_timeout)
   );

   eepw_poll_ctr #(.MAX_POLL(MAX_POLL)) u_poll (
      .clk(clk), .rst_n(rst_n), .clr_i(poll_clr), .inc_i(poll_inc),
      .last_o(poll_last)
   );

   eepw_frame_src #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .DEV_ID(DEV_ID),
                    .CHIP_SEL(CHIP_SEL)) u_frame (
      .addr_i(addr_q), .data_i(data_q), .step_i(step), .byte_o(cmd_byte)
   );

   p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !cmd_valid)
      else $error("command issued while idle");

   p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)))
      else $error("command dropped or changed before acceptance");
endmodule

// File: tb/eeprom_ackpoll_writer_tb_top.sv
module eeprom_ackpoll_writer_tb_top;
   localparam int MAXP    = 4;
   localparam int RSP_LAT = 2;
   localparam int NVEC    = 8;
   // {addr[39:24], data[23:16], busy_polls[15:8], nack_pos[7:4], 2'b0, exp_nack[1], exp_to[0]}
   localparam logic [39:0] VEC [NVEC] = '{
      {16'h0000, 8'h55, 8'd0, 4'd0, 2'b00, 1'b0, 1'b0},
      {16'h1234, 8'hA5, 8'd2, 4'd0, 2'b00, 1'b0, 1'b0},
      {16'hFFFF, 8'h00, 8'd3, 4'd0, 2'b00, 1'b0, 1'b0},
      {16'h00FF, 8'h3C, 8'd4, 4'd0, 2'b00, 1'b0, 1'b1},
      {16'hABCD, 8'h81, 8'd1, 4'd1, 2'b00, 1'b1, 1'b0},
      {16'h8001, 8'h7E, 8'd0, 4'd2, 2'b00, 1'b1, 1'b0},
      {16'h4321, 8'hFF, 8'd0, 4'd3, 2'b00, 1'b1, 1'b0},
      {16'h0100, 8'h01, 8'd9, 4'd0, 2'b00, 1'b0, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_data = '0;
   logic done, err_nack, err_timeout, cmd_valid, cmd_ready, rsp_valid, rsp_nack;
   logic [1:0] cmd_op;
   logic [7:0] cmd_byte;

   int total = 0, bad = 0, rdy_bad = 0, r9_bad = 0;
   int polls_left = 0, nack_pos = 0, pos = 0;
   int lg_n = 0, exp_n = 0;
   logic [9:0] lg [64];
   logic [9:0] ex [64];
   bit finished = 0;

   always #4 clk = ~clk;

   eeprom_ackpoll_writer #(.MAX_POLL(MAXP)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .done(done), .err_nack(err_nack),
      .err_timeout(err_timeout), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack)
   );

   // byte-level master model
   initial begin
      bit hs = 0, pend = 0, nk = 0;
      int dly = 0;
      logic [1:0] c_op = '0;
      logic [7:0] c_b = '0;
      cmd_ready = 1'b1; rsp_valid = 1'b0; rsp_nack = 1'b0;
      forever begin
         @(negedge clk);
         rsp_valid = 1'b0; rsp_nack = 1'b0;
         if (pend && cmd_valid) r9_bad++;
         if (hs) begin
            nk = 0;
            if (c_op == 2'd1) begin
               lg[lg_n] = {c_op, c_b};
               if (pos == 0) begin
                  nk = (polls_left > 0);
                  if (nk) polls_left--;
               end else nk = (pos == nack_pos);
               pos++;
            end else begin
               lg[lg_n] = {c_op, 8'h00};
               if (c_op == 2'd0) pos = 0;
            end
            if (lg_n < 63) lg_n++;
            pend = 1; dly = RSP_LAT;
         end else if (pend) begin
            dly--;
            if (dly == 0) begin
               rsp_valid = 1'b1; rsp_nack = nk; pend = 0;
            end
         end
         cmd_ready = !pend && !rsp_valid;
         hs = cmd_valid && cmd_ready && rst_n;
         c_op = cmd_op; c_b = cmd_byte;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic add_exp(input logic [9:0] e);
      ex[exp_n] = e; exp_n++;
   endtask

   task automatic build_exp(input logic [15:0] a, input logic [7:0] d, input int busy);
      int np = (busy < MAXP) ? busy : MAXP;
      for (int i = 0; i < np; i++) begin
         add_exp({2'd0, 8'h00}); add_exp({2'd1, 8'hA0}); add_exp({2'd2, 8'h00});
      end
      if (busy < MAXP) begin
         add_exp({2'd0, 8'h00}); add_exp({2'd1, 8'hA0});
         add_exp({2'd1, a[15:8]}); add_exp({2'd1, a[7:0]}); add_exp({2'd1, d});
         add_exp({2'd2, 8'h00});
      end
   endtask

   task automatic send_req(input logic [15:0] a, input logic [7:0] d);
      req_addr = a; req_data = d; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(output bit got);
      got = 0;
      for (int n = 0; n < 3000; n++) begin
         if (done) begin got = 1; break; end
         if (req_ready) rdy_bad++;
         @(negedge clk);
      end
   endtask

   task automatic chk_log(input string req);
      int mism = -1;
      chk(lg_n == exp_n, req, "frame length", lg_n, exp_n);
      for (int i = 0; i < exp_n && i < lg_n; i++)
         if (mism < 0 && lg[i] !== ex[i]) mism = i;
      chk(mism < 0, req, "frame content at entry", (mism < 0) ? 0 : lg[mism],
          (mism < 0) ? 0 : ex[mism]);
   endtask

   initial begin
      bit got;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready === 1'b1, "R1", "req_ready", req_ready, 1);
      chk({cmd_valid, done, err_nack, err_timeout} === 4'b0, "R1", "outputs quiet",
          {cmd_valid, done, err_nack, err_timeout}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         logic [39:0] v = VEC[i];
         polls_left = int'(v[15:8]); nack_pos = int'(v[7:4]);
         lg_n = 0; exp_n = 0; rdy_bad = 0;
         build_exp(v[39:24], v[23:16], int'(v[15:8]));
         send_req(v[39:24], v[23:16]);
         // R8: flags cleared right after acceptance; R2: busy
         chk({err_nack, err_timeout} === 2'b00, "R8", "flags cleared on accept",
             {err_nack, err_timeout}, 0);
         chk(req_ready === 1'b0, "R2", "ready low after accept", req_ready, 0);
         wait_done(got);
         chk(got, "R5", "done seen", got, 1);
         chk(req_ready === 1'b1, "R2", "ready with done", req_ready, 1);
         chk(err_timeout === v[0], "R7", "err_timeout", err_timeout, v[0]);
         chk(err_nack === v[1], "R6", "err_nack", err_nack, v[1]);
         chk_log("R3 R4 R5 R6 R7");
         chk(rdy_bad == 0, "R2", "ready high while busy", rdy_bad, 0);
         @(negedge clk);
         chk(done === 1'b0, "R5", "done one cycle", done, 0);
         repeat (3) @(negedge clk);
         chk({err_nack, err_timeout} === v[1:0], "R8", "flags hold while idle",
             {err_nack, err_timeout}, v[1:0]);
      end

      // R10: second request waits behind a busy write
      lg_n = 0; exp_n = 0; rdy_bad = 0; polls_left = 0; nack_pos = 0;
      build_exp(16'h2468, 8'h11, 0);
      build_exp(16'h1357, 8'h22, 0);
      send_req(16'h2468, 8'h11);
      req_addr = 16'h1357; req_data = 8'h22; req_valid = 1'b1;
      wait_done(got);
      chk(got && rdy_bad == 0, "R10", "first write finished alone", rdy_bad, 0);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready === 1'b0, "R10", "second request taken after done", req_ready, 0);
      wait_done(got);
      chk(got, "R10", "second done", got, 1);
      chk_log("R10");
      chk(r9_bad == 0, "R9", "command while response pending", r9_bad, 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule